// File: doc/BRIEF.md
# Sixteen-Bit Timer with Atomic Byte Access

This block is a 16-bit up-counter that software sees through an 8-bit register bus. The counter, the compare register and the capture (top) register each appear as a low byte and a high byte. All three share one temporary byte, so a 16-bit value is moved in one step even though the bus carries a single byte per access. A high-byte write only loads the temporary byte. The following low-byte write commits both halves at once. A low-byte read copies the matching high byte into the temporary byte, and a later high-byte read returns that copy.

The counter advances on cycles where the prescaler enable input is high and the clock-select field is nonzero. The wrap point depends on the mode. Normal mode wraps at 0xFFFF. A 10-bit PWM mode wraps at 0x3FF. A third mode restarts the counter after it reaches the value held in the capture register. An overflow flag and a compare flag, each with a mask bit, drive one interrupt request line that is gated by a global enable. An acknowledge input clears the flag being serviced.

Top module: `wide_timer`

## Requirements
- R1: After reset the counter, the temporary byte, both flags and the masks are zero, and irq_o is low.
- R2: The counter increments by one on each clock where tick_en_i is high and clock select (control B bits 2:0) is nonzero. It holds its value when clock select is zero or tick_en_i is low.
- R3: A write to a high byte (addresses 3, 5, 7) loads only the temporary byte. A write to the paired low byte (addresses 2, 4, 6) commits {temporary, data}. Writing the counter low byte 0x22 and then the high byte 0x55 leaves the counter at 0x0022.
- R4: A read of a low byte copies that register's high byte into the temporary byte. A read of a high byte returns the temporary byte. When the counter goes from 0xFFFF to 0x0000 and software reads high then low, the result is 0xFF00.
- R5: A counter low-byte write on a counting cycle replaces that cycle's increment.
- R6: Mode 0 (control A bits 1:0 and control B bits 4:3 all zero) wraps 0xFFFF to 0 and sets the overflow flag (flag register bit 0).
- R7: Mode 7 (control A bits 1:0 = 11, control B bit 3 = 1, bit 4 = 0) wraps from 0x3FF to 0 and sets the overflow flag.
- R8: Mode 12 (control B bits 4:3 = 11, control A bits 1:0 = 00) takes the counter from the capture register value to 0 without setting the overflow flag.
- R9: An increment that lands on the compare register value sets the compare flag (flag register bit 1). The compare register uses the buffered write of R3.
- R10: irq_o is high exactly when gie_i is high and some flag has its mask bit set (mask register address 8: bit 0 overflow, bit 1 compare).
- R11: A pulse on irq_ack_i while irq_o is high clears the enabled compare flag if one is pending, and otherwise clears the overflow flag.
- R12: Writing 1 to a bit of the flag register (address 9) clears that flag. A flag set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Prescaler enable; one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a low-byte read latches the high byte |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt taken; clears the serviced flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a low-byte counter write that lands on the same clock edge as an active count step. Only that case shows whether the write replaces the increment. The bench drives the write strobe and tick_en_i together for one edge and then keeps counting for one more edge. The stale high-byte read is reached a different way: the counter is wrapped from 0xFFFF with no low-byte read in between, so the temporary byte still holds the last written 0xFF when the high byte is read first.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef logic [3:0] addr_t;

  localparam addr_t ADDR_CTRL_A = 4'd0;
  localparam addr_t ADDR_CTRL_B = 4'd1;
  localparam addr_t ADDR_CNT_LO = 4'd2;
  localparam addr_t ADDR_CNT_HI = 4'd3;
  localparam addr_t ADDR_CMP_LO = 4'd4;
  localparam addr_t ADDR_CMP_HI = 4'd5;
  localparam addr_t ADDR_CAP_LO = 4'd6;
  localparam addr_t ADDR_CAP_HI = 4'd7;
  localparam addr_t ADDR_MASK   = 4'd8;
  localparam addr_t ADDR_FLAGS  = 4'd9;

  typedef enum logic [3:0] {
    MODE_NORMAL = 4'b0000,
    MODE_PWM10  = 4'b0111,
    MODE_CAPTOP = 4'b1100
  } mode_e;
endpackage

// File: rtl/tmr_byte_buf.sv
module tmr_byte_buf #(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hi_i,
  input  logic             rd_lo_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] hi_src_i,
  output logic [BUS_W-1:0] tmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tmp_o <= '0;
    else if (wr_hi_i) tmp_o <= wdata_i;
    else if (rd_lo_i) tmp_o <= hi_src_i;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W    = 16,
  parameter int PWM_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             cmp_evt_o
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] PWM_TOP = {{(CNT_W-PWM_BITS){1'b0}}, {PWM_BITS{1'b1}}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic cap_hit, pwm_hit, max_hit;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    cap_hit = (mode_i == MODE_CAPTOP) && (cnt_o == cap_i);
    pwm_hit = (mode_i == MODE_PWM10) && (cnt_o == PWM_TOP);
    max_hit = (cnt_o == {CNT_W{1'b1}});
    if (cap_hit || pwm_hit) nxt = '0;
    else                    nxt = cnt_o + ONE;
  end

  wire adv = step_i && !load_i;
  assign ovf_evt_o = adv && !cap_hit && (pwm_hit || max_hit);
  assign cmp_evt_o = adv && (nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (step_i) cnt_o <= nxt;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovf_evt_i,
  input  logic       cmp_evt_i,
  input  logic       mask_wr_i,
  input  logic       flag_wr_i,
  input  logic [1:0] wdata_i,
  input  logic       gie_i,
  input  logic       ack_i,
  output logic [1:0] mask_o,
  output logic [1:0] flags_o,
  output logic       irq_o
);
  logic [1:0] pend, clr, set;

  always_comb begin
    pend  = flags_o & mask_o;
    irq_o = gie_i && (pend != 2'b00);
    clr   = flag_wr_i ? wdata_i : 2'b00;
    if (ack_i && irq_o) begin
      if (pend[1]) clr[1] = 1'b1;
      else         clr[0] = 1'b1;
    end
    set = {cmp_evt_i, ovf_evt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      flags_o <= '0;
    end else begin
      if (mask_wr_i) mask_o <= wdata_i;
      flags_o <= (flags_o & ~clr) | set;
    end
  end
endmodule

// File: rtl/wide_timer.sv
module wide_timer #(
  parameter int BUS_W    = 8,
  parameter int PWM_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [3:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  output logic             irq_o
);
  import tmr_pkg::*;

  localparam int CNT_W = 2 * BUS_W;
  localparam int NWREG = 2; // 0: compare, 1: capture

  logic [BUS_W-1:0] ctrl_a_q, ctrl_b_q, tmp_q, hi_src;
  logic [CNT_W-1:0] wreg_q [NWREG];
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mask_q, flags_q;
  logic [3:0]       mode;
  logic [2:0]       cs;
  logic             ovf_evt, cmp_evt, step, cnt_wr, wr_hi, rd_lo;

  assign mode   = {ctrl_b_q[4:3], ctrl_a_q[1:0]};
  assign cs     = ctrl_b_q[2:0];
  assign step   = tick_en_i && (cs != 3'd0);
  assign cnt_wr = wr_en_i && (addr_i == ADDR_CNT_LO);
  assign wr_hi  = wr_en_i && (addr_i inside {ADDR_CNT_HI, ADDR_CMP_HI, ADDR_CAP_HI});
  assign rd_lo  = rd_en_i && (addr_i inside {ADDR_CNT_LO, ADDR_CMP_LO, ADDR_CAP_LO});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_CTRL_A) ctrl_a_q <= wdata_i;
      if (addr_i == ADDR_CTRL_B) ctrl_b_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NWREG; g++) begin : g_wreg
    localparam addr_t LO = addr_t'(ADDR_CMP_LO + 2 * g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      wreg_q[g] <= '0;
      else if (wr_en_i && addr_i == LO) wreg_q[g] <= {tmp_q, wdata_i};
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CMP_LO: hi_src = wreg_q[0][CNT_W-1:BUS_W];
      ADDR_CAP_LO: hi_src = wreg_q[1][CNT_W-1:BUS_W];
      default:     hi_src = cnt_q[CNT_W-1:BUS_W];
    endcase
  end

  tmr_byte_buf #(.BUS_W(BUS_W)) u_buf (
    .clk_i, .rst_ni, .wr_hi_i(wr_hi), .rd_lo_i(rd_lo),
    .wdata_i, .hi_src_i(hi_src), .tmp_o(tmp_q)
  );

  tmr_counter #(.CNT_W(CNT_W), .PWM_BITS(PWM_BITS)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .load_i(cnt_wr),
    .load_val_i({tmp_q, wdata_i}), .mode_i(mode),
    .cap_i(wreg_q[1]), .cmp_i(wreg_q[0]),
    .cnt_o(cnt_q), .ovf_evt_o(ovf_evt), .cmp_evt_o(cmp_evt)
  );

  tmr_irq u_irq (
    .clk_i, .rst_ni, .ovf_evt_i(ovf_evt), .cmp_evt_i(cmp_evt),
    .mask_wr_i(wr_en_i && addr_i == ADDR_MASK),
    .flag_wr_i(wr_en_i && addr_i == ADDR_FLAGS),
    .wdata_i(wdata_i[1:0]), .gie_i, .ack_i(irq_ack_i),
    .mask_o(mask_q), .flags_o(flags_q), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL_A: rdata_o = ctrl_a_q;
      ADDR_CTRL_B: rdata_o = ctrl_b_q;
      ADDR_CNT_LO: rdata_o = cnt_q[BUS_W-1:0];
      ADDR_CMP_LO: rdata_o = wreg_q[0][BUS_W-1:0];
      ADDR_CAP_LO: rdata_o = wreg_q[1][BUS_W-1:0];
      ADDR_CNT_HI, ADDR_CMP_HI, ADDR_CAP_HI: rdata_o = tmp_q;
      ADDR_MASK:   rdata_o = {{(BUS_W-2){1'b0}}, mask_q};
      ADDR_FLAGS:  rdata_o = {{(BUS_W-2){1'b0}}, flags_q};
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int BUS_W    = 8,
  parameter int PWM_BITS = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_en_i,
  input logic               wr_en_i,
  input logic [3:0]         addr_i,
  input logic [BUS_W-1:0]   wdata_i,
  input logic               gie_i,
  input logic               irq_o,
  input logic [2*BUS_W-1:0] cnt_q,
  input logic [2*BUS_W-1:0] cap_q,
  input logic [BUS_W-1:0]   tmp_q,
  input logic [1:0]         flags_q,
  input logic [3:0]         mode,
  input logic [2:0]         cs
);
  import tmr_pkg::*;
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] PWM_TOP = {{(CNT_W-PWM_BITS){1'b0}}, {PWM_BITS{1'b1}}};

  logic counting, lo_wr, hi_wr;
  assign counting = tick_en_i && (cs != 3'd0);
  assign lo_wr    = wr_en_i && (addr_i == ADDR_CNT_LO);
  assign hi_wr    = wr_en_i && (addr_i == ADDR_CNT_HI);

  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counting && !lo_wr) |=> $stable(cnt_q));

  p_hi_only_tmp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && !counting) |=> $stable(cnt_q));

  p_write_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> (cnt_q == {$past(tmp_q), $past(wdata_i)}));

  p_pwm_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && !lo_wr && mode == MODE_PWM10 && cnt_q == PWM_TOP) |=> (cnt_q == '0) && flags_q[0]);

  p_cap_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && !lo_wr && mode == MODE_CAPTOP && cnt_q == cap_q) |=> (cnt_q == '0));

  p_gie_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);
endmodule

bind wide_timer tmr_checker #(.BUS_W(BUS_W), .PWM_BITS(PWM_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .gie_i(gie_i), .irq_o(irq_o),
  .cnt_q(cnt_q), .cap_q(wreg_q[1]), .tmp_q(tmp_q), .flags_q(flags_q),
  .mode(mode), .cs(cs)
);

// File: tb/sim_wide_timer.sv
module sim_wide_timer;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_en_i = 0, wr_en_i = 0, rd_en_i = 0, gie_i = 0, irq_ack_i = 0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  wide_timer u0 (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_en_i = 1; addr_i = a; #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 0;
  endtask

  task automatic wr16(logic [3:0] lo, logic [15:0] v);
    wr(lo + 4'd1, v[15:8]); wr(lo, v[7:0]);
  endtask

  task automatic rd16(logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 4'd1, h); v = {h, l};
  endtask

  task automatic tick(int n);
    @(negedge clk_i); tick_en_i = 1;
    repeat (n) @(negedge clk_i);
    tick_en_i = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] f;
    rd16(4'd2, v); check("R1 counter", v, 0);
    rd(4'd9, f);   check("R1 flags", f, 0);
    rd(4'd8, f);   check("R1 mask", f, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr(4'd1, 8'h01); wr16(4'd2, 16'h1234);
    tick(5); rd16(4'd2, v); check("R2 count 5", v, 16'h1239);
    wr(4'd1, 8'h00); tick(10); rd16(4'd2, v); check("R2 stopped", v, 16'h1239);
  endtask

  task automatic t_order;
    logic [15:0] v;
    wr16(4'd2, 16'h0000);
    wr(4'd2, 8'h22); wr(4'd3, 8'h55);
    rd16(4'd2, v); check("R3 lo then hi", v, 16'h0022);
  endtask

  task automatic t_stale;
    logic [7:0] h, l, f;
    wr(4'd1, 8'h01); wr16(4'd2, 16'hFFFF);
    tick(1);
    rd(4'd3, h); rd(4'd2, l);
    check("R4 stale hi first", {h, l}, 16'hFF00);
    rd(4'd3, h); check("R4 hi after lo", h, 8'h00);
    rd(4'd9, f); check("R6 ovf flag", f & 8'h01, 1);
    wr(4'd9, 8'h03); rd(4'd9, f); check("R12 w1c", f, 0);
  endtask

  task automatic t_write_vs_tick;
    logic [15:0] v;
    wr(4'd3, 8'h00);
    @(negedge clk_i); tick_en_i = 1; wr_en_i = 1; addr_i = 4'd2; wdata_i = 8'h30;
    @(negedge clk_i); wr_en_i = 0;
    @(negedge clk_i); tick_en_i = 0;
    rd16(4'd2, v); check("R5 write replaces step", v, 16'h0031);
  endtask

  task automatic t_pwm10;
    logic [15:0] v; logic [7:0] f;
    wr(4'd0, 8'h03); wr(4'd1, 8'h09); wr(4'd9, 8'h03);
    wr16(4'd2, 16'h03FE);
    tick(1); rd(4'd9, f); check("R7 no ovf below top", f & 8'h01, 0);
    tick(1); rd16(4'd2, v); check("R7 wrap at 3FF", v, 0);
    rd(4'd9, f); check("R7 ovf flag", f & 8'h01, 1);
  endtask

  task automatic t_cap;
    logic [15:0] v; logic [7:0] f;
    wr(4'd0, 8'h00); wr(4'd1, 8'h19); wr(4'd9, 8'h03);
    wr16(4'd6, 16'h5010); wr16(4'd2, 16'h500F);
    tick(2); rd16(4'd2, v); check("R8 clear at cap", v, 0);
    rd(4'd9, f); check("R8 no ovf", f & 8'h01, 0);
  endtask

  task automatic t_cmp;
    logic [7:0] f;
    wr(4'd1, 8'h01); wr16(4'd4, 16'h10EF);
    wr16(4'd2, 16'h10EE); wr(4'd9, 8'h03);
    tick(1); rd(4'd9, f); check("R9 cmp flag", f, 8'h02);
    wr(4'd5, 8'h77);
    wr16(4'd2, 16'h10EE); wr(4'd9, 8'h03);
    tick(1); rd(4'd9, f); check("R9 hi-only cmp write", f, 8'h02);
  endtask

  task automatic t_irq;
    logic [7:0] f;
    wr16(4'd4, 16'h0001); wr(4'd8, 8'h01);
    wr16(4'd2, 16'hFFFF); wr(4'd9, 8'h03);
    tick(1); #1 check("R10 gie off", irq_o, 0);
    gie_i = 1; #1 check("R10 gie on", irq_o, 1);
    wr(4'd8, 8'h00); #1 check("R10 masked", irq_o, 0);
    wr(4'd8, 8'h03); tick(1);
    rd(4'd9, f); check("R9 both flags", f, 8'h03);
    @(negedge clk_i); irq_ack_i = 1; @(negedge clk_i); irq_ack_i = 0;
    rd(4'd9, f); check("R11 cmp first", f, 8'h01);
    check("R11 irq still", irq_o, 1);
    @(negedge clk_i); irq_ack_i = 1; @(negedge clk_i); irq_ack_i = 0;
    rd(4'd9, f); check("R11 ovf next", f, 8'h00);
    check("R11 irq low", irq_o, 0);
    gie_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset; t_count; t_order; t_stale; t_write_vs_tick;
    t_pwm10; t_cap; t_cmp; t_irq;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule